// File: doc/BRIEF.md
# Memory Write-Then-Verify Traffic Checker

This block is a self-checking traffic source for one small region of memory that several requester ports can reach. Each round it takes an 8-bit seed. It fills the region with an incrementing byte pattern, one single-byte write per transaction, and each write goes out on a writer port picked at random. When every byte has been written, it reads the whole region back in one transaction on a reader port picked at random. It compares every returned byte against the pattern.

The block advances one step per `initiate_i` pulse. A request that the memory side does not accept changes nothing, so the same operation is offered again on a later pulse. A passing check increments the completion counter and draws a fresh seed from a free-running 16-bit maximal-length LFSR. A failing check reports the lowest failing byte index together with the expected and observed values. When flush traffic is enabled, an occasional whole-region flush request goes out in place of the step, and the state does not change.

Port indices are LFSR bits reduced modulo the port count. A flush is issued when the low LFSR byte reads zero on an initiate cycle, which is one chance in 256. When a flush is drawn, it takes the request channel for that pulse, and the normal step is simply retried on a later pulse.

Top module: `mem_wv_checker`

## Requirements
- R1: After reset the block is idle with store count 0, `done_cnt_o` = 0, `err_valid_o` = 0, and the first round uses seed `RST_SEED` (default 8'hA5), so the first write carries 8'hA5.
- R2: In idle, an initiate that is not taken by a flush or a base change offers a write: `req_cmd_o` = 0, `req_size_o` = 1, `req_addr_o` = base + store count, `req_wdata_o` = (seed + store count) mod 256, and `req_port_o` < `N_WR`.
- R3: An offered write or read with `req_ready_i` low leaves the state and the store count unchanged, so the next initiate offers the identical operation.
- R4: A response to an accepted write increments the store count. The block then goes to ready when the count equals `REGION_BYTES`, and back to idle otherwise.
- R5: In ready, an initiate offers a read: `req_cmd_o` = 1, `req_addr_o` = base, `req_size_o` = `REGION_BYTES`, and `req_port_o` < `N_RD`.
- R6: An initiate while a write or read is outstanding offers no write or read.
- R7: A read response in which byte i (bits 8i+7:8i of `rsp_rdata_i`) equals (seed + i) mod 256 for every i increments `done_cnt_o` by one, raises no error, clears the store count, draws a new seed and returns to idle.
- R8: A read response with any mismatch pulses `err_valid_o` with `err_code_o` = 1, `err_idx_o` = the lowest failing index, and `err_exp_o`/`err_obs_o` = expected/observed byte. `done_cnt_o` is unchanged, and the block returns to idle with store count 0 and the same seed.
- R9: A response while neither a write nor a read is outstanding pulses `err_valid_o` with `err_code_o` = 2 and leaves the state and the store count unchanged.
- R10: With `flush_en_i` high, an initiate on a cycle where the low LFSR byte is zero offers a flush instead (`req_cmd_o` = 2, `req_addr_o` = base, `req_size_o` = `REGION_BYTES`, `req_port_o` < `N_WR`), and the state does not change. With `flush_en_i` low, no flush is ever offered.
- R11: `base_set_i` in idle or ready loads `base_addr_i`, forces idle and clears the store count, and no request is offered on that cycle. `base_set_i` while an operation is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| initiate_i | input | 1 | Step pulse |
| flush_en_i | input | 1 | Allows random flush requests |
| base_set_i | input | 1 | Load a new region base |
| base_addr_i | input | ADDR_W | New region base |
| req_valid_o | output | 1 | Request offered this cycle |
| req_ready_i | input | 1 | Memory side accepts the request |
| req_port_o | output | PORT_W | Requester port index |
| req_cmd_o | output | 2 | 0 write, 1 read, 2 flush |
| req_addr_o | output | ADDR_W | Start address |
| req_size_o | output | SIZE_W | Size in bytes |
| req_wdata_o | output | 8 | Write byte |
| rsp_valid_i | input | 1 | Response pulse |
| rsp_rdata_i | input | 8*REGION_BYTES | Read bytes, byte i at bits 8i+7:8i |
| done_cnt_o | output | DONE_W | Passed checks |
| err_valid_o | output | 1 | Error pulse |
| err_code_o | output | 2 | 1 mismatch, 2 unexpected response |
| err_idx_o | output | IDX_W | Lowest failing byte index |
| err_exp_o | output | 8 | Expected byte |
| err_obs_o | output | 8 | Observed byte |

## Verification
The bench rejects a write and then checks that the identical write is offered again. A design that advanced on the offer instead of the accept would skip a byte and break the address sequence. It pulses initiate and base change while a write is outstanding, where a leaky design would issue a duplicate request or move to another region. It also corrupts one byte of a read, which must report index 2 without counting a completion; the round after that failure must restart at offset 0 with the old seed. The last group covers a response in idle, which must be flagged without changing the store count, and a long run with flushes enabled, which must produce region-sized flushes while the pending write stays where it was.

// File: rtl/mwv_pkg.sv
package mwv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR_WAIT = 2'd1,
    ST_READY   = 2'd2,
    ST_RD_WAIT = 2'd3
  } mwv_state_e;

  localparam logic [1:0] CMD_WRITE = 2'd0;
  localparam logic [1:0] CMD_READ  = 2'd1;
  localparam logic [1:0] CMD_FLUSH = 2'd2;

  localparam logic [1:0] ERR_MISMATCH = 2'd1;
  localparam logic [1:0] ERR_UNEXP    = 2'd2;
endpackage

// File: rtl/mwv_lfsr.sv
module mwv_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  // Galois form, steps every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else q <= q >> 1;
  end

  assign state_o = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R10
endmodule

// File: rtl/mwv_compare.sv
module mwv_compare #(
  parameter int RB    = 4,
  parameter int IDX_W = (RB > 1) ? $clog2(RB) : 1
) (
  input  logic [7:0]      seed_i,
  input  logic [8*RB-1:0] data_i,
  output logic            mis_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]      exp_o,
  output logic [7:0]      obs_o
);
  logic [7:0]    exp_b [RB];
  logic [7:0]    obs_b [RB];
  logic [RB-1:0] bad;

  for (genvar g = 0; g < RB; g++) begin : g_byte
    assign exp_b[g] = seed_i + 8'(g);
    assign obs_b[g] = data_i[8*g +: 8];
    assign bad[g]   = exp_b[g] != obs_b[g];
  end

  // lowest failing index wins
  always_comb begin
    idx_o = '0;
    exp_o = exp_b[0];
    obs_o = obs_b[0];
    for (int i = RB - 1; i >= 0; i--) begin
      if (bad[i]) begin
        idx_o = IDX_W'(i);
        exp_o = exp_b[i];
        obs_o = obs_b[i];
      end
    end
  end

  assign mis_o = |bad;

  always_comb begin
    if (mis_o) begin
      AST_MIS_BYTE_DIFFERS: assert (exp_o != obs_o); // R8
    end
  end
endmodule

// File: rtl/mem_wv_checker.sv
module mem_wv_checker
  import mwv_pkg::*;
#(
  parameter int          N_WR         = 3,
  parameter int          N_RD         = 2,
  parameter int          REGION_BYTES = 4,
  parameter int          ADDR_W       = 16,
  parameter int          DONE_W       = 16,
  parameter logic [7:0]  RST_SEED     = 8'hA5,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1,
  localparam int NP     = (N_WR > N_RD) ? N_WR : N_RD,
  localparam int PORT_W = (NP > 1) ? $clog2(NP) : 1,
  localparam int SIZE_W = $clog2(REGION_BYTES + 1),
  localparam int IDX_W  = (REGION_BYTES > 1) ? $clog2(REGION_BYTES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      initiate_i,
  input  logic                      flush_en_i,
  input  logic                      base_set_i,
  input  logic [ADDR_W-1:0]         base_addr_i,
  output logic                      req_valid_o,
  input  logic                      req_ready_i,
  output logic [PORT_W-1:0]         req_port_o,
  output logic [1:0]                req_cmd_o,
  output logic [ADDR_W-1:0]         req_addr_o,
  output logic [SIZE_W-1:0]         req_size_o,
  output logic [7:0]                req_wdata_o,
  input  logic                      rsp_valid_i,
  input  logic [8*REGION_BYTES-1:0] rsp_rdata_i,
  output logic [DONE_W-1:0]         done_cnt_o,
  output logic                      err_valid_o,
  output logic [1:0]                err_code_o,
  output logic [IDX_W-1:0]          err_idx_o,
  output logic [7:0]                err_exp_o,
  output logic [7:0]                err_obs_o
);
  localparam int CNT_W = SIZE_W;

  mwv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        seed_q;
  logic [ADDR_W-1:0] base_q;
  logic [DONE_W-1:0] done_q;
  logic [15:0]       rnd;

  logic              pend, base_ok, flush_hit, op_try, acc;
  logic [PORT_W-1:0] wr_port, rd_port;
  logic              mis;
  logic [IDX_W-1:0]  mis_idx;
  logic [7:0]        mis_exp, mis_obs;
  logic [CNT_W-1:0]  cnt_inc;

  mwv_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  mwv_compare #(.RB(REGION_BYTES), .IDX_W(IDX_W)) u_cmp (
    .seed_i (seed_q),
    .data_i (rsp_rdata_i),
    .mis_o  (mis),
    .idx_o  (mis_idx),
    .exp_o  (mis_exp),
    .obs_o  (mis_obs)
  );

  assign pend      = (state_q == ST_WR_WAIT) || (state_q == ST_RD_WAIT);
  assign base_ok   = base_set_i && !pend;
  assign flush_hit = flush_en_i && initiate_i && !base_ok && (rnd[7:0] == 8'h00);
  assign op_try    = initiate_i && !base_ok && !flush_hit && !pend;
  assign acc       = op_try && req_ready_i;
  assign wr_port   = PORT_W'(rnd[15:8] % N_WR);
  assign rd_port   = PORT_W'(rnd[15:8] % N_RD);
  assign cnt_inc   = cnt_q + CNT_W'(1);

  always_comb begin
    req_valid_o = flush_hit || op_try;
    req_wdata_o = seed_q + 8'(cnt_q);
    if (flush_hit) begin
      req_cmd_o  = CMD_FLUSH;
      req_port_o = wr_port;
      req_addr_o = base_q;
      req_size_o = SIZE_W'(REGION_BYTES);
    end else if (state_q == ST_IDLE) begin
      req_cmd_o  = CMD_WRITE;
      req_port_o = wr_port;
      req_addr_o = base_q + ADDR_W'(cnt_q);
      req_size_o = SIZE_W'(1);
    end else begin
      req_cmd_o  = CMD_READ;
      req_port_o = rd_port;
      req_addr_o = base_q;
      req_size_o = SIZE_W'(REGION_BYTES);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      seed_q  <= RST_SEED;
      base_q  <= '0;
      done_q  <= '0;
    end else if (base_ok) begin
      base_q  <= base_addr_i;
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (acc) begin
      state_q <= (state_q == ST_IDLE) ? ST_WR_WAIT : ST_RD_WAIT;
    end else if (rsp_valid_i && state_q == ST_WR_WAIT) begin
      cnt_q   <= cnt_inc;
      state_q <= (cnt_inc == CNT_W'(REGION_BYTES)) ? ST_READY : ST_IDLE;
    end else if (rsp_valid_i && state_q == ST_RD_WAIT) begin
      cnt_q   <= '0;
      state_q <= ST_IDLE;
      if (!mis) begin
        done_q <= done_q + DONE_W'(1);
        seed_q <= rnd[7:0];
      end
    end
  end

  // error report, registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o <= 1'b0;
      err_code_o  <= '0;
      err_idx_o   <= '0;
      err_exp_o   <= '0;
      err_obs_o   <= '0;
    end else begin
      err_valid_o <= 1'b0;
      if (rsp_valid_i && !pend) begin
        err_valid_o <= 1'b1;
        err_code_o  <= ERR_UNEXP;
      end else if (rsp_valid_i && state_q == ST_RD_WAIT && mis) begin
        err_valid_o <= 1'b1;
        err_code_o  <= ERR_MISMATCH;
        err_idx_o   <= mis_idx;
        err_exp_o   <= mis_exp;
        err_obs_o   <= mis_obs;
      end
    end
  end

  assign done_cnt_o = done_q;

  AST_WR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_cmd_o == CMD_WRITE) |->
      (req_size_o == SIZE_W'(1) && int'(req_port_o) < N_WR)); // R2
  AST_REJECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !rsp_valid_i && !base_set_i) |=>
      ($stable(state_q) && $stable(cnt_q))); // R3
  AST_LAST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && state_q == ST_WR_WAIT && cnt_q == CNT_W'(REGION_BYTES - 1)) |=>
      (state_q == ST_READY)); // R4
  AST_RD_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_cmd_o == CMD_READ) |->
      (req_addr_o == base_q && req_size_o == SIZE_W'(REGION_BYTES) &&
       int'(req_port_o) < N_RD)); // R5
  AST_PEND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> !(req_valid_o && req_cmd_o != CMD_FLUSH)); // R6
  AST_DONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_cnt_o != $past(done_cnt_o)) |-> (done_cnt_o == $past(done_cnt_o) + DONE_W'(1))); // R7
  AST_MIS_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && err_code_o == ERR_MISMATCH) |-> $stable(done_cnt_o)); // R8
  AST_UNEXP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !pend && !base_set_i && !initiate_i) |=>
      ($stable(state_q) && $stable(cnt_q))); // R9
  AST_FLUSH_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_cmd_o == CMD_FLUSH) |->
      (flush_en_i && req_addr_o == base_q && req_size_o == SIZE_W'(REGION_BYTES) &&
       int'(req_port_o) < N_WR)); // R10
  AST_BASE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_set_i && pend) |=> $stable(base_q)); // R11
endmodule

// File: tb/mem_wv_checker_bench.sv
module mem_wv_checker_bench;
  localparam int N_WR   = 3;
  localparam int N_RD   = 2;
  localparam int RB     = 4;
  localparam int ADDR_W = 16;
  localparam int PORT_W = 2;
  localparam int SIZE_W = 3;
  localparam int IDX_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic initiate = 1'b0, flush_en = 1'b0, base_set = 1'b0, req_ready = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic rsp_valid = 1'b0;
  logic [8*RB-1:0] rsp_rdata = '0;
  logic req_valid_o;
  logic [PORT_W-1:0] req_port_o;
  logic [1:0] req_cmd_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [SIZE_W-1:0] req_size_o;
  logic [7:0] req_wdata_o;
  logic [15:0] done_cnt_o;
  logic err_valid_o;
  logic [1:0] err_code_o;
  logic [IDX_W-1:0] err_idx_o;
  logic [7:0] err_exp_o, err_obs_o;

  always #5 clk = ~clk;

  mem_wv_checker u_mem_wv_checker (
    .clk_i(clk), .rst_ni(rst_n), .initiate_i(initiate), .flush_en_i(flush_en),
    .base_set_i(base_set), .base_addr_i(base_addr), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready), .req_port_o(req_port_o), .req_cmd_o(req_cmd_o),
    .req_addr_o(req_addr_o), .req_size_o(req_size_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata), .done_cnt_o(done_cnt_o),
    .err_valid_o(err_valid_o), .err_code_o(err_code_o), .err_idx_o(err_idx_o),
    .err_exp_o(err_exp_o), .err_obs_o(err_obs_o)
  );

  typedef struct packed {
    logic        is_read;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        chk_data;
  } item_t;

  item_t exp_q[$];
  logic [7:0] mem [256];
  logic [7:0] seed = 8'hA5;
  logic [15:0] base = '0;
  int n_chk = 0, n_fail = 0, done_exp = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops expected items on every accepted write/read
  always begin
    @(negedge clk);
    #3;
    if (rst_n && req_valid_o && req_ready && req_cmd_o != 2'd2) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 request with nothing expected", {30'd0, req_cmd_o}, 32'hFF);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (!it.is_read) begin
          chk(req_cmd_o == 2'd0, "R2 write cmd", req_cmd_o, 0);
          chk(req_addr_o == it.addr, "R2 write addr", req_addr_o, it.addr);
          chk(req_size_o == 1, "R2 write size", req_size_o, 1);
          chk(int'(req_port_o) < N_WR, "R2 writer port range", req_port_o, N_WR);
          if (it.chk_data) chk(req_wdata_o == it.data, "R2 write data", req_wdata_o, it.data);
          else seed = req_wdata_o;
          mem[req_addr_o[7:0]] = req_wdata_o;
        end else begin
          chk(req_cmd_o == 2'd1, "R5 read cmd", req_cmd_o, 1);
          chk(req_addr_o == it.addr, "R5 read addr", req_addr_o, it.addr);
          chk(req_size_o == RB, "R5 read size", req_size_o, RB);
          chk(int'(req_port_o) < N_RD, "R5 reader port range", req_port_o, N_RD);
        end
      end
    end
  end

  task automatic pulse_init(input bit rdy, output bit v);
    @(negedge clk);
    initiate = 1'b1; req_ready = rdy;
    #3 v = req_valid_o;
    @(negedge clk);
    initiate = 1'b0; req_ready = 1'b0;
  endtask

  task automatic pulse_rsp(input logic [8*RB-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic set_base(input logic [15:0] a, input bit with_init, output bit v);
    @(negedge clk);
    base_set = 1'b1; base_addr = a; initiate = with_init; req_ready = 1'b1;
    #3 v = req_valid_o;
    @(negedge clk);
    base_set = 1'b0; initiate = 1'b0; req_ready = 1'b0;
  endtask

  task automatic write_one(input int k, input bit chkd, input bit reject, input bit pend_test);
    item_t it;
    bit v;
    it.is_read = 1'b0; it.addr = base + 16'(k); it.data = seed + 8'(k); it.chk_data = chkd;
    exp_q.push_back(it);
    if (reject) begin
      pulse_init(1'b0, v);
      chk(v, "R3 rejected write still offered", v, 1);
      chk(exp_q.size() == 1, "R3 reject consumed nothing", exp_q.size(), 1);
    end
    pulse_init(1'b1, v);
    chk(exp_q.size() == 0, "R2 write issued", exp_q.size(), 0);
    if (pend_test) begin
      pulse_init(1'b1, v);
      chk(!v, "R6 initiate while write outstanding", v, 0);
      set_base(16'h0099, 1'b0, v);
      chk(!v, "R11 base change while pending offers nothing", v, 0);
    end
    pulse_rsp('0);
  endtask

  task automatic read_one(input bit corrupt, input int ci);
    item_t it;
    bit v;
    logic [8*RB-1:0] d;
    logic [7:0] good;
    it.is_read = 1'b1; it.addr = base; it.data = '0; it.chk_data = 1'b0;
    exp_q.push_back(it);
    pulse_init(1'b1, v);
    chk(exp_q.size() == 0, "R5 read issued", exp_q.size(), 0);
    for (int i = 0; i < RB; i++) d[8*i +: 8] = mem[8'(base + 16'(i))];
    good = seed + 8'(ci);
    if (corrupt) d[8*ci +: 8] = d[8*ci +: 8] ^ 8'h3C;
    pulse_rsp(d);
    #3;
    if (!corrupt) begin
      done_exp++;
      chk(done_cnt_o == 16'(done_exp), "R7 completion count", done_cnt_o, done_exp);
      chk(!err_valid_o, "R7 no error on match", err_valid_o, 0);
    end else begin
      chk(done_cnt_o == 16'(done_exp), "R8 count held on mismatch", done_cnt_o, done_exp);
      chk(err_valid_o && err_code_o == 2'd1, "R8 mismatch code", {err_valid_o, err_code_o}, 3'b101);
      chk(err_idx_o == IDX_W'(ci), "R8 failing index", err_idx_o, ci);
      chk(err_exp_o == good, "R8 expected byte", err_exp_o, good);
      chk(err_obs_o == (good ^ 8'h3C), "R8 observed byte", err_obs_o, good ^ 8'h3C);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit v;
    int nfl, bad;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(done_cnt_o == 0, "R1 reset count", done_cnt_o, 0);
    chk(!err_valid_o, "R1 reset error", err_valid_o, 0);
    chk(!req_valid_o, "R1 reset request", req_valid_o, 0);

    set_base(16'h0010, 1'b0, v);
    base = 16'h0010;
    // round 1: reset seed, reject, pending pulses
    write_one(0, 1'b1, 1'b0, 1'b0);
    chk(mem[8'h10] == 8'hA5, "R1 reset seed in first write", mem[8'h10], 8'hA5);
    write_one(1, 1'b1, 1'b1, 1'b0);
    write_one(2, 1'b1, 1'b0, 1'b1);
    write_one(3, 1'b1, 1'b0, 1'b0);
    // R4: four writes reach ready, so the next step is a read
    read_one(1'b0, 0);

    // R9: response with nothing outstanding
    pulse_rsp('0);
    #3;
    chk(err_valid_o && err_code_o == 2'd2, "R9 unexpected response code", {err_valid_o, err_code_o}, 3'b110);

    // round 2: mismatch at byte 2, state must still be idle at offset 0
    write_one(0, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < RB; k++) write_one(k, 1'b1, 1'b0, 1'b0);
    read_one(1'b1, 2);
    // round 3: restarts at offset 0 with the same seed
    for (int k = 0; k < RB; k++) write_one(k, 1'b1, 1'b0, 1'b0);
    read_one(1'b0, 0);

    // round 4: base change in ready and in idle
    write_one(0, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < RB; k++) write_one(k, 1'b1, 1'b0, 1'b0);
    set_base(16'h0080, 1'b1, v);
    chk(!v, "R11 base change suppresses request", v, 0);
    base = 16'h0080;
    write_one(0, 1'b1, 1'b0, 1'b0);
    write_one(1, 1'b1, 1'b0, 1'b0);
    set_base(16'h0040, 1'b0, v);
    base = 16'h0040;
    for (int k = 0; k < RB; k++) write_one(k, 1'b1, 1'b0, 1'b0);
    read_one(1'b0, 0);

    // R10: flushes with enable high, none with it low, state kept
    nfl = 0; bad = 0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      initiate = 1'b1; flush_en = 1'b1; req_ready = 1'b0;
      #3;
      if (req_valid_o && req_cmd_o == 2'd2) begin
        nfl++;
        if (req_addr_o != base || req_size_o != RB || int'(req_port_o) >= N_WR) bad++;
      end else if (!(req_valid_o && req_cmd_o == 2'd0 && req_addr_o == base)) bad++;
    end
    @(negedge clk);
    initiate = 1'b0; flush_en = 1'b0;
    chk(nfl > 0, "R10 flushes seen", nfl, 1);
    chk(bad == 0, "R10 flush shape and held write", bad, 0);
    nfl = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      initiate = 1'b1; req_ready = 1'b0;
      #3;
      if (req_valid_o && req_cmd_o == 2'd2) nfl++;
    end
    @(negedge clk);
    initiate = 1'b0;
    chk(nfl == 0, "R10 no flush when disabled", nfl, 0);
    write_one(0, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < RB; k++) write_one(k, 1'b1, 1'b0, 1'b0);
    read_one(1'b0, 0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule